// File: doc/BRIEF.md
# Quadrature Encoder Speed Meter

This block turns the two square-wave outputs of an optical quadrature encoder into a signed speed figure. The two channels come from sensors set a quarter period apart, so which one leads gives the direction of rotation. The block counts encoder pulses over a fixed sampling window. Each pulse adds one in one direction and subtracts one in the other. When the window closes, the net count is frozen as the speed value and the running count restarts from zero.

A host processor reads the frozen speed, a sticky "new sample" flag and the window length through a small register port with fixed read latency. The host can also change the window length, which is given in clock cycles. By default the window is 10 ms long at the configured clock frequency. Writing a new length starts a fresh window at once.

Top module: `quad_speed_meter`

## Requirements
- R1: Both encoder inputs pass through a two-flop synchronizer. Each rising edge of synchronized channel A is one pulse: it adds 1 when synchronized channel B is low (forward) and subtracts 1 when B is high (reverse). A pulse changes the running count three clock edges after the input change.
- R2: The sampling window lasts `win_len` clock cycles. It repeats without software help as long as no new length is written. At the last cycle of each window, the running count (including any pulse counted in that cycle) is copied into the speed register and the running count goes back to zero. A window with no pulses reports 0.
- R3: The running count is a signed CNT_W-bit value that saturates at +(2^(CNT_W-1))-1 and at -(2^(CNT_W-1)) instead of wrapping.
- R4: Register offsets on `bus_addr`: 0 reads the speed, sign-extended to DATA_W bits; 1 reads the window length; 2 reads the status, with bit 0 as the new-sample flag and the other bits zero; 3 reads zero.
- R5: A read request in one cycle returns `bus_rvalid` high with the data in the very next cycle, and only then.
- R6: A write of a nonzero value to offset 1 sets the window length and starts a new window: the timer and the running count both go to zero in that cycle. A write of zero to offset 1 is ignored.
- R7: Writes to offsets 0, 2 and 3 change nothing.
- R8: The new-sample flag is set when a window ends. It is cleared by a read of offset 2, and that read returns the value the flag had before the clear. If a window ends in the same cycle as the read, the flag stays set.
- R9: After reset the speed, running count, timer and new-sample flag are all zero, and the window length is CLK_HZ/1000*WIN_MS cycles.
- R10: A window that holds pulses in both directions reports the net signed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The bench builds the block with CLK_HZ=10000 and WIN_MS=10. This gives a 100-cycle default window, so a 1 ms encoder period maps to 10 cycles per pulse, and 8-cycle pulses fit ten to a window. It also sets CNT_W=6, which puts the saturation limits at +31 and -32. A 400-cycle window with 40 pulses in one direction is then enough to drive the count against each limit. These values keep pure-direction windows, mixed windows, empty windows and back-to-back free-running windows all within a few thousand cycles.

// File: rtl/qsm_pkg.sv
package qsm_pkg;

  typedef enum logic [1:0] {
    REG_SPEED  = 2'd0,
    REG_WINDOW = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } qsm_reg_e;

  localparam int STATUS_NEW_BIT = 0;

endpackage

// File: rtl/qsm_edge_detect.sv
module qsm_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a,
  input  logic enc_b,
  output logic step_up,
  output logic step_dn
);

  logic [SYNC_STAGES-1:0] a_chain_q, a_chain_d;
  logic [SYNC_STAGES-1:0] b_chain_q, b_chain_d;
  logic                   a_prev_q, a_prev_d;
  logic                   a_s, b_s, a_rise;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        a_chain_d = enc_a;
        b_chain_d = enc_b;
      end
    end else begin : g_many
      always_comb begin
        a_chain_d = {a_chain_q[SYNC_STAGES-2:0], enc_a};
        b_chain_d = {b_chain_q[SYNC_STAGES-2:0], enc_b};
      end
    end
  endgenerate

  assign a_s = a_chain_q[SYNC_STAGES-1];
  assign b_s = b_chain_q[SYNC_STAGES-1];

  always_comb begin
    a_prev_d = a_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_chain_q <= '0;
      b_chain_q <= '0;
      a_prev_q  <= 1'b0;
    end else begin
      a_chain_q <= a_chain_d;
      b_chain_q <= b_chain_d;
      a_prev_q  <= a_prev_d;
    end
  end

  assign a_rise  = a_s & ~a_prev_q;
  assign step_up = a_rise & ~b_s;
  assign step_dn = a_rise &  b_s;

  // R1: an edge of A lasts a single cycle
  p_step_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |=> !(step_up || step_dn));

endmodule

// File: rtl/qsm_window_timer.sv
module qsm_window_timer #(
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  input  logic             restart,
  output logic             win_end
);

  logic [WIN_W-1:0] tick_q, tick_d;
  logic             at_last;

  assign at_last = (tick_q == (win_len - WIN_W'(1)));
  assign win_end = at_last & ~restart;

  always_comb begin
    if (restart || at_last) begin
      tick_d = '0;
    end else begin
      tick_d = tick_q + WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_d;
    end
  end

  // R2: the timer never runs past the programmed length
  p_tick_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < win_len);

  // R6: a restart puts the timer back to the first cycle of a window
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> tick_q == '0);

endmodule

// File: rtl/qsm_pulse_counter.sv
module qsm_pulse_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             win_end,
  input  logic             restart,
  output logic [CNT_W-1:0] speed
);

  localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] run_q, run_d, speed_q, speed_d, stepped;
  logic             hold_hi, hold_lo;

  assign hold_hi = step_up && (run_q == MAX_V);
  assign hold_lo = step_dn && (run_q == MIN_V);

  always_comb begin
    stepped = run_q;
    if (step_up && !hold_hi) begin
      stepped = run_q + CNT_W'(1);
    end else if (step_dn && !hold_lo) begin
      stepped = run_q - CNT_W'(1);
    end
  end

  always_comb begin
    run_d   = stepped;
    speed_d = speed_q;
    if (restart) begin
      run_d = '0;
    end else if (win_end) begin
      run_d   = '0;
      speed_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      speed_q <= '0;
    end else begin
      run_q   <= run_d;
      speed_q <= speed_d;
    end
  end

  assign speed = speed_q;

  // R3: count stays at the positive limit
  p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == MAX_V && step_up && !win_end && !restart) |=> run_q == MAX_V);

  // R3: count stays at the negative limit
  p_sat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == MIN_V && step_dn && !win_end && !restart) |=> run_q == MIN_V);

  // R2: speed only moves at a window end
  p_speed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(speed_q));

  // R2: running count starts at zero after a window end
  p_clear_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> run_q == '0);

endmodule

// File: rtl/qsm_regs.sv
module qsm_regs
  import qsm_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] WIN_RESET = 32'd500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  speed,
  input  logic              win_end,
  output logic [DATA_W-1:0] win_len,
  output logic              restart,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  logic [DATA_W-1:0] win_q, win_d;
  logic              new_q, new_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;
  logic              rvalid_q, rvalid_d;
  logic              wr_win, rd_status;
  logic [DATA_W-1:0] speed_ext;

  generate
    if (DATA_W > CNT_W) begin : g_ext
      assign speed_ext = {{(DATA_W-CNT_W){speed[CNT_W-1]}}, speed};
    end else begin : g_trunc
      assign speed_ext = speed[DATA_W-1:0];
    end
  endgenerate

  assign wr_win    = bus_wr && (bus_addr == REG_WINDOW) && (bus_wdata != '0);
  assign rd_status = bus_rd && (bus_addr == REG_STATUS);
  assign restart   = wr_win;

  always_comb begin
    win_d = wr_win ? bus_wdata : win_q;
    if (win_end) begin
      new_d = 1'b1;
    end else if (rd_status) begin
      new_d = 1'b0;
    end else begin
      new_d = new_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (qsm_reg_e'(bus_addr))
      REG_SPEED:  rd_mux = speed_ext;
      REG_WINDOW: rd_mux = win_q;
      REG_STATUS: rd_mux[STATUS_NEW_BIT] = new_q;
      default:    rd_mux = '0;
    endcase
    rdata_d  = bus_rd ? rd_mux : rdata_q;
    rvalid_d = bus_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= DATA_W'(WIN_RESET);
      new_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      win_q    <= win_d;
      new_q    <= new_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign win_len    = win_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R5: data comes back exactly one cycle after a request
  p_rvalid_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R5: no valid without a request
  p_rvalid_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  // R8: a window end always leaves the flag set
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> new_q);

  // R6: writing zero leaves the length alone
  p_zero_len_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_WINDOW && bus_wdata == '0) |=> $stable(win_q));

  // R6: the window length is never zero
  p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_q != '0);

endmodule

// File: rtl/quad_speed_meter.sv
module quad_speed_meter #(
  parameter int CLK_HZ      = 50000000,
  parameter int WIN_MS      = 10,
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  localparam logic [31:0] WIN_RESET = 32'((CLK_HZ / 1000) * WIN_MS);

  logic              step_up, step_dn;
  logic              win_end, restart;
  logic [DATA_W-1:0] win_len;
  logic [CNT_W-1:0]  speed;

  qsm_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .enc_a   (enc_a),
    .enc_b   (enc_b),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  qsm_window_timer #(.WIN_W(DATA_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_len (win_len),
    .restart (restart),
    .win_end (win_end)
  );

  qsm_pulse_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (step_up),
    .step_dn (step_dn),
    .win_end (win_end),
    .restart (restart),
    .speed   (speed)
  );

  qsm_regs #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .WIN_RESET (WIN_RESET)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .speed      (speed),
    .win_end    (win_end),
    .win_len    (win_len),
    .restart    (restart),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

endmodule

// File: tb/tb_quad_speed_meter.sv
module tb_quad_speed_meter;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int WIN    = 100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enc_a = 1'b0;
  logic              enc_b = 1'b0;
  logic [1:0]        bus_addr = 2'd0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid;

  int    compared = 0;
  int    mismatched = 0;
  int    elapsed = 0;
  bit    finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  quad_speed_meter #(
    .CLK_HZ (10000),
    .WIN_MS (10),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R5: unexpected read data %0d, expected no response", $signed(bus_rdata));
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ($signed(bus_rdata) != e) begin
          mismatched++;
          $display("FAIL %s: got %0d expected %0d", t, $signed(bus_rdata), e);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      elapsed++;
    end
  endtask

  task automatic wait_until(input int t);
    if (t > elapsed) tick(t - elapsed);
  endtask

  task automatic bus_read(input logic [1:0] a, input int e, input string t);
    bus_addr = a;
    bus_rd   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    tick(1);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input int d);
    bus_addr  = a;
    bus_wdata = DATA_W'(d);
    bus_wr    = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  // restart a window and reset the local cycle reference
  task automatic new_window(input int len);
    bus_write(2'd1, len);
    elapsed = 0;
  endtask

  // one encoder period of 8 cycles; fwd: A rises while B is low
  task automatic pulse(input bit fwd);
    if (fwd) begin
      enc_a = 1; enc_b = 0; tick(2);
      enc_a = 1; enc_b = 1; tick(2);
      enc_a = 0; enc_b = 1; tick(2);
      enc_a = 0; enc_b = 0; tick(2);
    end else begin
      enc_a = 0; enc_b = 1; tick(2);
      enc_a = 1; enc_b = 1; tick(2);
      enc_a = 1; enc_b = 0; tick(2);
      enc_a = 0; enc_b = 0; tick(2);
    end
  endtask

  task automatic pulses(input int n, input bit fwd);
    for (int i = 0; i < n; i++) pulse(fwd);
  endtask

  task automatic drain();
    tick(3);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R5: %0d reads without response, expected 0", exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run not finished, expected completion");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R9 reset state, R4 map
    bus_read(2'd0, 0,   "R9 speed after reset");
    bus_read(2'd1, WIN, "R9 default window length");
    bus_read(2'd2, 0,   "R9 status after reset");
    bus_read(2'd3, 0,   "R4 spare offset reads zero");
    drain();

    // R1/R2 forward window: +10
    new_window(WIN);
    pulses(10, 1'b1);
    wait_until(WIN + 2);
    bus_read(2'd2, 1,  "R8 new-sample set after window end");
    bus_read(2'd2, 0,  "R8 new-sample cleared by read");
    bus_read(2'd0, 10, "R1 forward window speed");
    drain();

    // R7 writes to other offsets ignored
    bus_write(2'd0, 55);
    bus_write(2'd2, 1);
    bus_write(2'd3, 7);
    bus_read(2'd0, 10, "R7 speed unchanged by write");
    bus_read(2'd2, 0,  "R7 status unchanged by write");
    drain();

    // R1/R4 reverse window: -10 sign-extended
    new_window(WIN);
    pulses(10, 1'b0);
    wait_until(WIN + 2);
    bus_read(2'd0, -10, "R4 reverse speed sign-extended");
    drain();

    // R10 mixed windows
    new_window(WIN);
    pulses(6, 1'b1);
    pulses(4, 1'b0);
    wait_until(WIN + 2);
    bus_read(2'd0, 2, "R10 net of 6 fwd 4 rev");
    drain();

    new_window(WIN);
    pulses(3, 1'b1);
    pulses(7, 1'b0);
    wait_until(WIN + 2);
    bus_read(2'd0, -4, "R10 net of 3 fwd 7 rev");
    drain();

    // R2 empty window reports zero (counter cleared)
    new_window(WIN);
    wait_until(WIN + 2);
    bus_read(2'd0, 0, "R2 empty window");
    drain();

    // R2 free-running: two windows back to back without a write
    new_window(WIN);
    pulses(10, 1'b1);
    wait_until(WIN + 4);
    pulses(10, 1'b0);
    wait_until(2 * WIN + 2);
    bus_read(2'd0, -10, "R2 second free-running window");
    drain();

    // R6 zero write ignored, nonzero write sets length
    bus_write(2'd1, 0);
    bus_read(2'd1, WIN, "R6 zero length write ignored");
    drain();

    // R6 restart clears the running count
    new_window(WIN);
    pulses(5, 1'b1);
    new_window(WIN);
    pulses(2, 1'b1);
    wait_until(WIN + 2);
    bus_read(2'd0, 2, "R6 restart discards earlier pulses");
    drain();

    // R3 saturation at both limits
    new_window(400);
    bus_read(2'd1, 400, "R6 new window length read back");
    pulses(40, 1'b1);
    wait_until(402);
    bus_read(2'd0, 31, "R3 positive saturation");
    drain();

    new_window(400);
    pulses(40, 1'b0);
    wait_until(402);
    bus_read(2'd0, -32, "R3 negative saturation");
    drain();

    new_window(WIN);
    tick(2);
    summary();
  end

endmodule